// File: doc/BRIEF.md
# H-Bridge Gate Decoder with Protection Latch

This block is the digital control core of a brushed DC motor H-bridge. Three host pins, `in1_i`, `in2_i` and `en_i`, select direction, brake or stop through a fixed decode. The block drives four gate enables: a high side and a low side for each of the two motor terminals. The host never supplies a dead time. Whenever a switch in a leg turns off, the block keeps the other switch of that leg off for a parameterised number of clock cycles. A switch that turns off and back on in the same leg is not delayed, so PWM applied on `en_i` chops the low sides directly.

Short-circuit, overcurrent and over-temperature flags come in as synchronous digital inputs. Any of them latches a fault, forces every gate off and pulls `fault_no` low. The latch is released only by a logic-supply power-on reset, which is signalled by the logic-supply monitor dropping below its falling threshold. Two comparator flags, one per threshold, give the logic-supply monitor its hysteresis. A separate motor-supply undervoltage flag forces the gates off without latching anything.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: After reset, and for as long as the logic supply has not been reported good, all four gates are low and `fault_no` is high, whatever the host pins show.
- R2: The terminal-1 high side (`hs1_o`) requests on when `in2_i` is 0. The terminal-2 high side (`hs2_o`) requests on when `in1_i` is 0. With both pins at 0, both high sides are on whatever the level of `en_i`.
- R3: The terminal-1 low side (`ls1_o`) requests on when `in2_i`=1 and `en_i`=1. The terminal-2 low side (`ls2_o`) requests on when `in1_i`=1 and `en_i`=1. `in1_i`=`in2_i`=1 brakes with both low sides when `en_i`=1, and stops with all gates off when `en_i`=0.
- R4: `in1_i`=1, `in2_i`=0, `en_i`=1 drives forward (`hs1_o` and `ls2_o` on). `in1_i`=0, `in2_i`=1, `en_i`=1 drives reverse (`hs2_o` and `ls1_o` on).
- R5: A gate change caused by the host pins appears after the first rising clock edge that samples the new pins, unless a dead-time hold applies.
- R6: When a switch turns off at an edge, the other switch of the same leg may turn on no earlier than DEAD_CYC+1 edges later. It turns on at exactly that edge if it is still requested.
- R7: A switch that turns off and is requested again, with the other switch of its leg still off, turns back on at the next edge with no dead-time hold.
- R8: A high level on any of `flt_short_i`, `flt_ocp_i` or `flt_ot_i` at an edge, while the logic supply is good, forces all gates low and `fault_no` low from that edge on. Both persist after the flag clears.
- R9: The fault latch clears only when the logic supply goes bad (`vdd_fall_i`=0). Gates stay off until the supply is good again.
- R10: The logic supply becomes good on an edge that sees `vdd_rise_i`=1. Once good, it stays good while `vdd_fall_i`=1, even with `vdd_rise_i`=0.
- R11: `vcc_uv_i`=1 at an edge forces all gates low at that edge without touching `fault_no`. Normal decode, subject to R6, resumes once it clears.
- R12: The high and low side of the same leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in1_i | input | 1 | Host control pin 1 (terminal-2 leg select) |
| in2_i | input | 1 | Host control pin 2 (terminal-1 leg select) |
| en_i | input | 1 | Low-side enable / PWM input |
| vdd_rise_i | input | 1 | Logic supply above rising threshold |
| vdd_fall_i | input | 1 | Logic supply above falling threshold |
| vcc_uv_i | input | 1 | Motor supply undervoltage |
| flt_short_i | input | 1 | Output short-circuit detected |
| flt_ocp_i | input | 1 | Overcurrent detected |
| flt_ot_i | input | 1 | Over-temperature detected |
| hs1_o | output | 1 | Terminal-1 high-side gate enable |
| ls1_o | output | 1 | Terminal-1 low-side gate enable |
| hs2_o | output | 1 | Terminal-2 high-side gate enable |
| ls2_o | output | 1 | Terminal-2 low-side gate enable |
| fault_no | output | 1 | Latched fault, active low |

## Verification
Each gate output, the fault pin and the supply state sit one register behind the inputs. Pin, fault and motor-supply changes therefore show up after the first edge that samples them. A dead-time hold adds DEAD_CYC further edges before the other switch of a leg may close. The bench changes inputs on the falling clock edge and advances its reference model on each rising edge. It compares all five outputs on the following falling edge, so every result is read one full edge after it is due. Long runs after each direction change cover the whole hold window, and short `en_i` toggles show that re-enabling the same switch carries no hold.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int unsigned NUM_LEGS = 2;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_pair_t;

  // which switch of a leg the pending hold blocks
  typedef enum logic {
    BLK_HI = 1'b0,
    BLK_LO = 1'b1
  } blk_side_e;
endpackage

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
(
  input  logic                       in1_i,
  input  logic                       in2_i,
  input  logic                       en_i,
  output leg_pair_t [NUM_LEGS-1:0]   req_o
);
  // leg 0 = terminal 1 (steered by in2), leg 1 = terminal 2 (steered by in1)
  always_comb begin
    req_o[0].hi = ~in2_i;
    req_o[0].lo = in2_i & en_i;
    req_o[1].hi = ~in1_i;
    req_o[1].lo = in1_i & en_i;
  end
endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vdd_rise_i,
  input  logic vdd_fall_i,
  input  logic vcc_uv_i,
  input  logic flt_short_i,
  input  logic flt_ocp_i,
  input  logic flt_ot_i,
  output logic kill_o,
  output logic fault_o
);
  logic ok_q, ok_d;
  logic flt_q, flt_d;
  logic any_flt;

  always_comb begin
    any_flt = flt_short_i | flt_ocp_i | flt_ot_i;
    ok_d    = ok_q ? vdd_fall_i : vdd_rise_i;
    // logic supply loss acts as the power-on reset of the latch
    flt_d   = ok_d & (flt_q | any_flt);
    kill_o  = ~ok_d | flt_d | vcc_uv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      flt_q <= flt_d;
    end
  end

  assign fault_o = flt_q;
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  leg_pair_t req_i,
  input  logic      kill_i,
  output leg_pair_t gate_o
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 2);

  leg_pair_t    g_q;
  logic [CW-1:0] cnt_q;
  blk_side_e    side_q;
  logic         busy, hi_d, lo_d, hi_off, lo_off;

  always_comb begin
    busy   = (cnt_q != '0);
    hi_d   = ~kill_i & req_i.hi & (g_q.hi | (~g_q.lo & ~(busy & (side_q == BLK_HI))));
    lo_d   = ~kill_i & req_i.lo & (g_q.lo | (~g_q.hi & ~(busy & (side_q == BLK_LO))));
    hi_off = g_q.hi & ~hi_d;
    lo_off = g_q.lo & ~lo_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_q    <= '0;
      cnt_q  <= '0;
      side_q <= BLK_HI;
    end else begin
      g_q.hi <= hi_d;
      g_q.lo <= lo_d;
      if (lo_off) begin
        cnt_q  <= CW'(DEAD_CYC);
        side_q <= BLK_HI;
      end else if (hi_off) begin
        cnt_q  <= CW'(DEAD_CYC);
        side_q <= BLK_LO;
      end else if (busy) begin
        cnt_q  <= cnt_q - CW'(1);
      end
    end
  end

  assign gate_o = g_q;
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in1_i,
  input  logic in2_i,
  input  logic en_i,
  input  logic vdd_rise_i,
  input  logic vdd_fall_i,
  input  logic vcc_uv_i,
  input  logic flt_short_i,
  input  logic flt_ocp_i,
  input  logic flt_ot_i,
  output logic hs1_o,
  output logic ls1_o,
  output logic hs2_o,
  output logic ls2_o,
  output logic fault_no
);
  leg_pair_t [NUM_LEGS-1:0] req;
  leg_pair_t [NUM_LEGS-1:0] gate;
  logic kill, fault;

  hb_decode u_dec (
    .in1_i (in1_i),
    .in2_i (in2_i),
    .en_i  (en_i),
    .req_o (req)
  );

  hb_supervisor u_sup (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vdd_rise_i  (vdd_rise_i),
    .vdd_fall_i  (vdd_fall_i),
    .vcc_uv_i    (vcc_uv_i),
    .flt_short_i (flt_short_i),
    .flt_ocp_i   (flt_ocp_i),
    .flt_ot_i    (flt_ot_i),
    .kill_o      (kill),
    .fault_o     (fault)
  );

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req[l]),
      .kill_i (kill),
      .gate_o (gate[l])
    );
  end

  assign hs1_o    = gate[0].hi;
  assign ls1_o    = gate[0].lo;
  assign hs2_o    = gate[1].hi;
  assign ls2_o    = gate[1].lo;
  assign fault_no = ~fault;
endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk #(
  parameter int unsigned DEAD_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic vdd_fall_i,
  input logic vcc_uv_i,
  input logic hs1_o,
  input logic ls1_o,
  input logic hs2_o,
  input logic ls2_o,
  input logic fault_no
);
  logic all_off;
  assign all_off = !(hs1_o || ls1_o || hs2_o || ls2_o);

  a_r12_leg1_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs1_o && ls1_o));
  a_r12_leg2_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs2_o && ls2_o));

  a_r6_hs1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ls1_o) && (DEAD_CYC > 0)) |=> !hs1_o);
  a_r6_ls1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hs1_o) && (DEAD_CYC > 0)) |=> !ls1_o);
  a_r6_hs2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ls2_o) && (DEAD_CYC > 0)) |=> !hs2_o);
  a_r6_ls2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hs2_o) && (DEAD_CYC > 0)) |=> !ls2_o);

  a_r8_fault_gates_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_no |-> all_off);
  a_r8_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_no && vdd_fall_i) |=> !fault_no);

  a_r11_vcc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_uv_i |=> all_off);
endmodule

bind hbridge_gate_ctrl hb_gate_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vdd_fall_i (vdd_fall_i),
  .vcc_uv_i   (vcc_uv_i),
  .hs1_o      (hs1_o),
  .ls1_o      (ls1_o),
  .hs2_o      (hs2_o),
  .ls2_o      (ls2_o),
  .fault_no   (fault_no)
);

// File: tb/hbridge_gate_ctrl_test.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_test;
  localparam int DEAD = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in1 = 1'b0, in2 = 1'b0, en = 1'b0;
  logic vrise = 1'b0, vfall = 1'b0, vuv = 1'b0;
  logic fs = 1'b0, fo = 1'b0, ft = 1'b0;
  logic hs1, ls1, hs2, ls2, fault_n;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  // reference state: index 0 hs1, 1 ls1, 2 hs2, 3 ls2
  int m_ok = 0, m_flt = 0;
  int m_g[4] = '{0, 0, 0, 0};
  int m_hold[4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  hbridge_gate_ctrl #(.DEAD_CYC(DEAD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in1_i(in1), .in2_i(in2), .en_i(en),
    .vdd_rise_i(vrise), .vdd_fall_i(vfall), .vcc_uv_i(vuv),
    .flt_short_i(fs), .flt_ocp_i(fo), .flt_ot_i(ft),
    .hs1_o(hs1), .ls1_o(ls1), .hs2_o(hs2), .ls2_o(ls2), .fault_no(fault_n)
  );

  task automatic model_edge();
    int nok, nflt, kill;
    int req[4];
    int ng[4];
    nok  = m_ok ? int'(vfall) : int'(vrise);
    nflt = (nok != 0) && (m_flt != 0 || fs || fo || ft);
    kill = (nok == 0) || (nflt != 0) || vuv;
    req[0] = !in2;
    req[1] = in2 && en;
    req[2] = !in1;
    req[3] = in1 && en;
    for (int s = 0; s < 4; s++) begin
      int o = s ^ 1;
      ng[s] = (kill == 0) && (req[s] != 0) &&
              (m_g[s] != 0 || (m_g[o] == 0 && m_hold[s] == 0));
    end
    for (int s = 0; s < 4; s++) begin
      int o = s ^ 1;
      if (m_g[o] != 0 && ng[o] == 0) m_hold[s] = DEAD;
      else if (m_hold[s] > 0) m_hold[s]--;
    end
    for (int s = 0; s < 4; s++) m_g[s] = ng[s];
    m_ok = nok;
    m_flt = nflt;
  endtask

  task automatic compare();
    logic [4:0] act, exp;
    act = {fault_n, hs1, ls1, hs2, ls2};
    exp = {logic'(m_flt == 0), logic'(m_g[0] != 0), logic'(m_g[1] != 0),
           logic'(m_g[2] != 0), logic'(m_g[3] != 0)};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs {fault_n,hs1,ls1,hs2,ls2} act=%b exp=%b at %0t",
               tag, act, exp, $time);
    end
    total++;
    if ((hs1 && ls1) || (hs2 && ls2)) begin
      bad++;
      $display("FAIL R12: shoot-through act=%b exp=no leg with both on", act[3:0]);
    end
  endtask

  task automatic run(int n, string t);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic pins(logic a, logic b, logic e);
    in1 = a; in2 = b; en = e;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    if (!finished) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if ({fault_n, hs1, ls1, hs2, ls2} !== 5'b10000) begin
      bad++;
      $display("FAIL R1: reset act=%b exp=10000", {fault_n, hs1, ls1, hs2, ls2});
    end
    rst_ni = 1'b1;
    pins(0, 0, 0);
    run(3, "R1");            // supply not good: high-side request ignored
    vrise = 1; vfall = 1;
    run(4, "R10");           // supply good, both high sides
    pins(0, 0, 1);
    run(3, "R2");
    vrise = 0;
    run(3, "R10");           // hysteresis keeps it good
    pins(1, 0, 1);
    run(12, "R6");           // leg 2 flips high->low through the hold
    run(3, "R4");
    pins(0, 1, 1);
    run(12, "R6");
    run(2, "R4");
    pins(1, 1, 1);
    run(10, "R3");           // brake
    pins(1, 1, 0);
    run(8, "R3");            // stop
    pins(0, 0, 0);
    run(3, "R5");
    pins(1, 0, 1);
    run(12, "R6");
    for (int k = 0; k < 6; k++) begin
      en = ~en;
      run(1 + (k % 2), "R7");
    end
    en = 1;
    run(3, "R7");
    vuv = 1;
    run(3, "R11");
    vuv = 0;
    run(10, "R11");
    for (int f = 0; f < 3; f++) begin
      pins(1, 0, 1);
      run(8, "R4");
      fs = (f == 0); fo = (f == 1); ft = (f == 2);
      run(1, "R8");
      fs = 0; fo = 0; ft = 0;
      run(4, "R8");
      pins(0, 0, 0);
      run(2, "R8");
      vfall = 0;
      run(2, "R9");
      vfall = 1;
      run(2, "R9");          // rising flag still low: stays off
      vrise = 1;
      run(4, "R9");
      vrise = 0;
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule